// File: doc/BRIEF.md
# Ring Lane Hop-Limited Forwarder

This block is one lane of a node in a packet ring. Packets arrive from the upstream neighbour on one of two receive links, an on-board link or a cable link. Each packet is either passed to the downstream neighbour or taken off the ring. The decision depends on a hop counter carried in the low bits of the packet's first beat and on a hop budget that every node shares. A local source can put new packets onto the lane whenever no transit packet holds it. Every beat that the lane accepts from the ring is also copied to a node-local output, whether or not the packet travels on.

Two per-node selection bits choose the active receive link and the active transmit link. A change to either bit takes effect only between packets. The lane's travel direction depends only on whether its lane index is even or odd. It is reported on a constant output.

Top module: `ring_lane_fwd`

## Requirements
- R1: A received packet that is not removed goes out unchanged except for the hop field, bits [HOP_W-1:0] of its first beat, which leaves as the received value plus one modulo 2^HOP_W; later beats are not altered, and the receive link is held not-ready while the chosen transmit link is not ready.
- R2: When `cfg_hops` is below NODES and the received hop field equals `cfg_hops` (zero-extended), the packet is removed: no transmit valid for any of its beats, and the receive ready stays 1 from first to last beat.
- R3: When `cfg_hops` is NODES or more, no packet is removed, including one whose hop field equals the low bits of `cfg_hops`.
- R4: A transit packet has priority over injection: an injected beat is accepted only when no received packet is in progress or starting. A received packet that arrives during an injection waits for the injection's last beat. An injected packet leaves with hop field 1, which is its start count 0 plus the outgoing increment.
- R5: Receive select 0 takes the on-board link and 1 the cable link; the link that is not selected sees ready 0.
- R6: Transmit select 0 drives the on-board link and 1 the cable link; at most one transmit valid is high.
- R7: The selections in force are updated only while no packet is in progress, so a packet never changes link part-way through.
- R8: Each beat accepted from the ring, whether forwarded or removed, appears in the same cycle on the local output with its data unmodified; injected beats never appear there.
- R9: `lane_dir` is 1 for an even LANE_IDX (toward increasing node index) and 0 for an odd one, and no input can change it.
- R10: In reset both selections are 0 (on-board), no transmit or local valid is raised, and the cable receive link sees ready 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hops | input | CFG_W | Hop budget shared by all nodes |
| cfg_rx_sel | input | 1 | Requested receive link: 0 on-board, 1 cable |
| cfg_tx_sel | input | 1 | Requested transmit link: 0 on-board, 1 cable |
| lane_dir | output | 1 | Fixed direction: 1 increasing, 0 decreasing node index |
| rx_ob_valid | input | 1 | On-board receive valid |
| rx_ob_ready | output | 1 | On-board receive ready |
| rx_ob_data | input | DATA_W | On-board receive data |
| rx_ob_sop | input | 1 | On-board receive first beat |
| rx_ob_eop | input | 1 | On-board receive last beat |
| rx_cb_valid | input | 1 | Cable receive valid |
| rx_cb_ready | output | 1 | Cable receive ready |
| rx_cb_data | input | DATA_W | Cable receive data |
| rx_cb_sop | input | 1 | Cable receive first beat |
| rx_cb_eop | input | 1 | Cable receive last beat |
| inj_valid | input | 1 | Local injection valid |
| inj_ready | output | 1 | Local injection ready |
| inj_data | input | DATA_W | Local injection data |
| inj_sop | input | 1 | Local injection first beat |
| inj_eop | input | 1 | Local injection last beat |
| tx_ob_valid | output | 1 | On-board transmit valid |
| tx_ob_ready | input | 1 | On-board transmit ready |
| tx_ob_data | output | DATA_W | On-board transmit data |
| tx_ob_sop | output | 1 | On-board transmit first beat |
| tx_ob_eop | output | 1 | On-board transmit last beat |
| tx_cb_valid | output | 1 | Cable transmit valid |
| tx_cb_ready | input | 1 | Cable transmit ready |
| tx_cb_data | output | DATA_W | Cable transmit data |
| tx_cb_sop | output | 1 | Cable transmit first beat |
| tx_cb_eop | output | 1 | Cable transmit last beat |
| loc_valid | output | 1 | Local delivery valid |
| loc_data | output | DATA_W | Local delivery data |
| loc_sop | output | 1 | Local delivery first beat |
| loc_eop | output | 1 | Local delivery last beat |

## Verification
Forwarding and injection can compete for the output in the same cycle. The bench provokes this in two ways. First, it presents a received first beat and an injected first beat together while the transmit link is stalled, and checks that injection ready stays low and only the transit beat is offered. Second, it starts a received packet midway through a two-beat injection and checks that the receive ready stays low until the injection's last beat has gone. Each case is judged at the ports: injection ready, receive ready, transmit hop field and local valid are checked cycle by cycle, and the beat that waited must go out right after the winner's last beat.

// File: rtl/ring_lane_fwd.sv
`timescale 1ns/1ps
module ring_lane_fwd #(
  parameter int DATA_W   = 32,
  parameter int HOP_W    = 8,
  parameter int CFG_W    = 32,
  parameter int NODES    = 4,
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_hops,
  input  logic              cfg_rx_sel,
  input  logic              cfg_tx_sel,
  output logic              lane_dir,
  input  logic              rx_ob_valid,
  output logic              rx_ob_ready,
  input  logic [DATA_W-1:0] rx_ob_data,
  input  logic              rx_ob_sop,
  input  logic              rx_ob_eop,
  input  logic              rx_cb_valid,
  output logic              rx_cb_ready,
  input  logic [DATA_W-1:0] rx_cb_data,
  input  logic              rx_cb_sop,
  input  logic              rx_cb_eop,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [DATA_W-1:0] inj_data,
  input  logic              inj_sop,
  input  logic              inj_eop,
  output logic              tx_ob_valid,
  input  logic              tx_ob_ready,
  output logic [DATA_W-1:0] tx_ob_data,
  output logic              tx_ob_sop,
  output logic              tx_ob_eop,
  output logic              tx_cb_valid,
  input  logic              tx_cb_ready,
  output logic [DATA_W-1:0] tx_cb_data,
  output logic              tx_cb_sop,
  output logic              tx_cb_eop,
  output logic              loc_valid,
  output logic [DATA_W-1:0] loc_data,
  output logic              loc_sop,
  output logic              loc_eop
);

  localparam logic [CFG_W-1:0] NODES_C = CFG_W'(NODES);
  localparam logic [HOP_W-1:0] HOP_ONE = HOP_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_INJ, S_DROP} st_t;

  st_t state, mode, nxt;
  logic rx_sel_q, tx_sel_q;

  logic              rx_v, rx_s, rx_e, rx_rdy, tx_rdy;
  logic [DATA_W-1:0] rx_d;
  logic [HOP_W-1:0]  hop_in;
  logic              remove_en, hit;

  assign lane_dir = (LANE_IDX % 2 == 0);

  assign rx_v = rx_sel_q ? rx_cb_valid : rx_ob_valid;
  assign rx_d = rx_sel_q ? rx_cb_data  : rx_ob_data;
  assign rx_s = rx_sel_q ? rx_cb_sop   : rx_ob_sop;
  assign rx_e = rx_sel_q ? rx_cb_eop   : rx_ob_eop;
  assign tx_rdy = tx_sel_q ? tx_cb_ready : tx_ob_ready;

  assign hop_in    = rx_d[HOP_W-1:0];
  assign remove_en = cfg_hops < NODES_C;
  assign hit       = remove_en && (CFG_W'(hop_in) == cfg_hops);

  always_comb begin
    mode = state;
    if (state == S_IDLE) begin
      if (rx_v && rx_s)              mode = hit ? S_DROP : S_FWD;
      else if (inj_valid && inj_sop) mode = S_INJ;
      else                           mode = S_IDLE;
    end
  end

  assign rx_rdy    = (mode == S_DROP) || (mode == S_IDLE) || (mode == S_FWD && tx_rdy);
  assign inj_ready = (mode == S_IDLE) || (mode == S_INJ && tx_rdy);

  assign rx_ob_ready = rx_rdy && !rx_sel_q;
  assign rx_cb_ready = rx_rdy &&  rx_sel_q;

  logic              out_v, out_s, out_e;
  logic [DATA_W-1:0] out_d;

  always_comb begin
    out_v = 1'b0;
    out_s = 1'b0;
    out_e = 1'b0;
    out_d = rx_d;
    if (mode == S_FWD) begin
      out_v = rx_v;
      out_s = rx_s;
      out_e = rx_e;
      out_d = rx_s ? {rx_d[DATA_W-1:HOP_W], HOP_W'(hop_in + HOP_ONE)} : rx_d;
    end else if (mode == S_INJ) begin
      out_v = inj_valid;
      out_s = inj_sop;
      out_e = inj_eop;
      out_d = inj_sop ? {inj_data[DATA_W-1:HOP_W], HOP_ONE} : inj_data;
    end
  end

  assign tx_ob_valid = out_v && !tx_sel_q;
  assign tx_cb_valid = out_v &&  tx_sel_q;
  assign tx_ob_data  = out_d;
  assign tx_cb_data  = out_d;
  assign tx_ob_sop   = out_s;
  assign tx_cb_sop   = out_s;
  assign tx_ob_eop   = out_e;
  assign tx_cb_eop   = out_e;

  assign loc_valid = rx_v && rx_rdy && (mode == S_FWD || mode == S_DROP);
  assign loc_data  = rx_d;
  assign loc_sop   = rx_s;
  assign loc_eop   = rx_e;

  logic acc, acc_eop;
  always_comb begin
    acc     = 1'b0;
    acc_eop = 1'b0;
    if (mode == S_FWD || mode == S_DROP) begin
      acc     = rx_v && rx_rdy;
      acc_eop = rx_e;
    end else if (mode == S_INJ) begin
      acc     = inj_valid && inj_ready;
      acc_eop = inj_eop;
    end
    nxt = state;
    if (acc) nxt = acc_eop ? S_IDLE : mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rx_sel_q <= 1'b0;
      tx_sel_q <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == S_IDLE) begin
        rx_sel_q <= cfg_rx_sel;
        tx_sel_q <= cfg_tx_sel;
      end
    end
  end

  assert_drop_nostall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DROP) |-> (rx_ob_ready || rx_cb_ready));

  assert_drop_notx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DROP) |-> !(tx_ob_valid || tx_cb_valid));

  assert_rx_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_ob_ready, rx_cb_ready}));

  assert_tx_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_ob_valid, tx_cb_valid}));

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> ($stable(rx_sel_q) && $stable(tx_sel_q)));

  assert_transit_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && inj_ready) |-> !loc_valid);

endmodule

// File: tb/ring_lane_fwd_test.sv
`timescale 1ns/1ps
module ring_lane_fwd_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_hops = '0;
  logic        cfg_rx_sel = 1'b0, cfg_tx_sel = 1'b0;
  logic        lane_dir;
  logic        rx_ob_valid = 0, rx_ob_sop = 0, rx_ob_eop = 0, rx_ob_ready;
  logic        rx_cb_valid = 0, rx_cb_sop = 0, rx_cb_eop = 0, rx_cb_ready;
  logic [31:0] rx_ob_data = '0, rx_cb_data = '0;
  logic        inj_valid = 0, inj_sop = 0, inj_eop = 0, inj_ready;
  logic [31:0] inj_data = '0;
  logic        tx_ob_valid, tx_ob_sop, tx_ob_eop, tx_ob_ready = 1'b1;
  logic        tx_cb_valid, tx_cb_sop, tx_cb_eop, tx_cb_ready = 1'b1;
  logic [31:0] tx_ob_data, tx_cb_data, loc_data;
  logic        loc_valid, loc_sop, loc_eop;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ring_lane_fwd uut (
    .clk(clk), .rst_n(rst_n), .cfg_hops(cfg_hops), .cfg_rx_sel(cfg_rx_sel),
    .cfg_tx_sel(cfg_tx_sel), .lane_dir(lane_dir),
    .rx_ob_valid(rx_ob_valid), .rx_ob_ready(rx_ob_ready), .rx_ob_data(rx_ob_data),
    .rx_ob_sop(rx_ob_sop), .rx_ob_eop(rx_ob_eop),
    .rx_cb_valid(rx_cb_valid), .rx_cb_ready(rx_cb_ready), .rx_cb_data(rx_cb_data),
    .rx_cb_sop(rx_cb_sop), .rx_cb_eop(rx_cb_eop),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_data(inj_data),
    .inj_sop(inj_sop), .inj_eop(inj_eop),
    .tx_ob_valid(tx_ob_valid), .tx_ob_ready(tx_ob_ready), .tx_ob_data(tx_ob_data),
    .tx_ob_sop(tx_ob_sop), .tx_ob_eop(tx_ob_eop),
    .tx_cb_valid(tx_cb_valid), .tx_cb_ready(tx_cb_ready), .tx_cb_data(tx_cb_data),
    .tx_cb_sop(tx_cb_sop), .tx_cb_eop(tx_cb_eop),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_sop(loc_sop), .loc_eop(loc_eop)
  );

  // {rx_sel, tx_sel, cfg_hops, hop_in, expect_removed}
  localparam logic [42:0] VEC [8] = '{
    {1'b0, 1'b0, 32'd2,   8'd0,   1'b0},
    {1'b1, 1'b1, 32'd2,   8'd2,   1'b1},
    {1'b0, 1'b1, 32'd2,   8'd1,   1'b0},
    {1'b1, 1'b0, 32'd4,   8'd4,   1'b0},
    {1'b0, 1'b0, 32'd3,   8'd3,   1'b1},
    {1'b0, 1'b0, 32'd300, 8'd44,  1'b0},
    {1'b1, 1'b0, 32'd0,   8'd255, 1'b0},
    {1'b0, 1'b1, 32'd0,   8'd0,   1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_rx(input bit p, input logic [31:0] d, input bit s, input bit e, input bit v);
    rx_ob_valid = 0; rx_ob_sop = 0; rx_ob_eop = 0; rx_ob_data = '0;
    rx_cb_valid = 0; rx_cb_sop = 0; rx_cb_eop = 0; rx_cb_data = '0;
    if (p) begin rx_cb_valid = v; rx_cb_sop = s; rx_cb_eop = e; rx_cb_data = d; end
    else   begin rx_ob_valid = v; rx_ob_sop = s; rx_ob_eop = e; rx_ob_data = d; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state: selection forced to on-board even with cable requested
    cfg_rx_sel = 1'b1;
    drive_rx(1'b1, 32'h1234_5600, 1, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R10 tx valids in reset", {tx_ob_valid, tx_cb_valid}, 2'b00);
    chk("R10 local valid in reset", loc_valid, 1'b0);
    chk("R10 cable rx ready in reset", rx_cb_ready, 1'b0);
    chk("R9 lane_dir even lane", lane_dir, 1'b1);
    drive_rx(1'b0, '0, 0, 0, 0);
    cfg_rx_sel = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);

    // vector table: R1 R2 R3 R5 R6 R8
    for (int i = 0; i < 8; i++) begin
      logic rs, ts, dr;
      logic [31:0] ch, d;
      logic [7:0] h;
      {rs, ts, ch, h, dr} = VEC[i];
      @(negedge clk);
      cfg_rx_sel = rs; cfg_tx_sel = ts; cfg_hops = ch;
      @(posedge clk);
      @(negedge clk);
      d = {16'hBEEF, 8'(i), h};
      drive_rx(rs, d, 1, 1, 1);
      #1;
      if (dr) begin
        chk("R2 removed packet not sent", {tx_cb_valid, tx_ob_valid}, 2'b00);
        chk("R2 removed packet consumed", rs ? rx_cb_ready : rx_ob_ready, 1'b1);
      end else begin
        chk("R6 transmit link choice", {tx_cb_valid, tx_ob_valid}, ts ? 2'b10 : 2'b01);
        chk("R1 R3 forwarded data hop+1", ts ? tx_cb_data : tx_ob_data, {d[31:8], 8'(h + 8'd1)});
      end
      chk("R8 local copy valid", loc_valid, 1'b1);
      chk("R8 local copy data", loc_data, d);
      chk("R5 unselected rx ready", rs ? rx_ob_ready : rx_cb_ready, 1'b0);
      @(posedge clk);
      @(negedge clk);
      drive_rx(rs, '0, 0, 0, 0);
    end

    // R7: selection change mid-packet waits for the boundary
    @(negedge clk);
    cfg_rx_sel = 0; cfg_tx_sel = 0; cfg_hops = 32'd9;
    @(posedge clk); @(negedge clk);
    drive_rx(1'b0, 32'hAAAA_0005, 1, 0, 1); #1;
    chk("R1 first beat on-board", tx_ob_data, 32'hAAAA_0006);
    @(posedge clk); @(negedge clk);
    cfg_rx_sel = 1; cfg_tx_sel = 1;
    drive_rx(1'b0, 32'h1111_2222, 0, 0, 1); #1;
    chk("R7 mid-packet stays on-board tx", {tx_cb_valid, tx_ob_valid}, 2'b01);
    chk("R7 mid-packet stays on-board rx", rx_ob_ready, 1'b1);
    chk("R1 later beat unchanged", tx_ob_data, 32'h1111_2222);
    @(posedge clk); @(negedge clk);
    drive_rx(1'b0, 32'h3333_4444, 0, 1, 1); #1;
    chk("R7 last beat on-board", {tx_cb_valid, tx_ob_valid}, 2'b01);
    @(posedge clk); @(negedge clk);
    drive_rx(1'b1, 32'h5555_0007, 1, 1, 1); #1;
    chk("R7 next packet on cable tx", {tx_cb_valid, tx_ob_valid}, 2'b10);
    chk("R7 next packet on cable rx", rx_cb_ready, 1'b1);
    @(posedge clk); @(negedge clk);
    drive_rx(1'b1, '0, 0, 0, 0);

    // R1 backpressure and R4 same-cycle competition
    tx_cb_ready = 0;
    drive_rx(1'b1, 32'h6666_0003, 1, 1, 1);
    inj_valid = 1; inj_sop = 1; inj_eop = 1; inj_data = 32'h7777_0077;
    #1;
    chk("R1 rx held while tx stalled", rx_cb_ready, 1'b0);
    chk("R4 injection blocked by transit", inj_ready, 1'b0);
    chk("R4 transit beat offered", tx_cb_data, 32'h6666_0004);
    @(posedge clk); @(negedge clk);
    tx_cb_ready = 1; #1;
    chk("R1 rx accepted once tx ready", rx_cb_ready, 1'b1);
    chk("R4 injection still blocked", inj_ready, 1'b0);
    @(posedge clk); @(negedge clk);
    drive_rx(1'b1, '0, 0, 0, 0); #1;
    chk("R4 injection proceeds", inj_ready, 1'b1);
    chk("R4 injected hop field", tx_cb_data, 32'h7777_0001);
    chk("R8 injected beat not local", loc_valid, 1'b0);
    @(posedge clk); @(negedge clk);
    inj_valid = 0; inj_sop = 0; inj_eop = 0;

    // R4: received packet arrives during a two-beat injection
    @(negedge clk);
    inj_valid = 1; inj_sop = 1; inj_eop = 0; inj_data = 32'h8888_00FF; #1;
    chk("R4 injection first beat hop", tx_cb_data, 32'h8888_0001);
    @(posedge clk); @(negedge clk);
    inj_sop = 0; inj_eop = 1; inj_data = 32'h9999_9999;
    drive_rx(1'b1, 32'hABCD_0000, 1, 1, 1); #1;
    chk("R4 rx waits for injection end", rx_cb_ready, 1'b0);
    chk("R4 injection last beat sent", tx_cb_data, 32'h9999_9999);
    chk("R8 no local during wait", loc_valid, 1'b0);
    @(posedge clk); @(negedge clk);
    inj_valid = 0; inj_eop = 0; #1;
    chk("R4 waiting rx now accepted", rx_cb_ready, 1'b1);
    chk("R1 waiting rx forwarded", tx_cb_data, 32'hABCD_0001);
    @(posedge clk); @(negedge clk);
    drive_rx(1'b1, '0, 0, 0, 0);

    // R2: three-beat removal with stalled transmit link
    cfg_hops = 32'd2; tx_cb_ready = 0;
    @(posedge clk); @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      drive_rx(1'b1, 32'hD0D0_0002 + 32'(b << 8), b == 0, b == 2, 1); #1;
      chk("R2 removal never stalls", rx_cb_ready, 1'b1);
      chk("R2 removal sends nothing", tx_cb_valid, 1'b0);
      chk("R8 removed beat delivered locally", loc_valid, 1'b1);
      @(posedge clk); @(negedge clk);
    end
    drive_rx(1'b1, '0, 0, 0, 0);
    tx_cb_ready = 1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule